// File: doc/BRIEF.md
# Data-Map Address Compacting Mapper

This block turns a two-dimensional memory access, given as a column coordinate (x) and a row coordinate (y), into one linear physical address. A data map seldom spans the full x range, so a plain `{y, x}` join would leave holes in physical memory wherever the high x bits stay unused. The mapper instead keeps only as many x bits as the current data map needs and lays the row number directly on top of them. Rectangular maps of any width therefore pack densely.

The number of x bits in use is held in a small configuration register. The row is moved into place by a log-staged shifter. Each stage moves the row field down by a power of two, and one bit of the shift amount controls each stage. One instance serves one memory bank. Accesses enter with a valid strobe and leave one clock later with the address, a valid strobe and a flag. The flag marks an x coordinate that does not fit the configured width.

Top module: `dmap_packer`

## Requirements
- R1: During and after reset `out_valid`, `out_addr` and `out_range_err` are 0. The configured x width is 16, so the mapping is a plain `{y, x}` join.
- R2: A write with `cfg_we` high and `cfg_xbits` in 1..16 sets the x width W. Accesses presented in later cycles use it.
- R3: A write of `cfg_xbits` equal to 0 or 17..31 is ignored, and the previous width stays in force.
- R4: One cycle after an access with `in_valid` high, `out_addr` equals `(in_y << W) | (in_x & (2^W - 1))`. Bits above `W+15` are 0.
- R5: `out_valid` equals `in_valid` of the previous cycle.
- R6: `out_range_err` is 1 with a valid result exactly when the access had an x bit set at position W or above. It is 0 in every cycle where `out_valid` is 0.
- R7: In a cycle after `in_valid` was low, `out_addr` keeps its previous value.
- R8: With W = 16 the address is `{y, x}`. With W = 1 it is `(y << 1) | x[0]`.
- R9: When a configuration write and an access fall in the same cycle, the access is mapped with the width in force before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the x-width register |
| cfg_xbits | input | 5 | Number of x bits in use (legal 1..16) |
| in_valid | input | 1 | Access present |
| in_x | input | 16 | Column coordinate |
| in_y | input | 16 | Row coordinate |
| out_valid | output | 1 | Mapped address present |
| out_addr | output | 32 | Packed physical address |
| out_range_err | output | 1 | x coordinate exceeded the configured width |

## Verification
The hardest case to reach is a width change that lands in the same clock as an access, because that access must still see the old width. A second hard case is an illegal width code, which must leave no trace. Directed steps write a new width in the very cycle an access is presented. They also write codes 0 and 17 between accesses whose range flag reveals the width still in force. A long random stream then mixes legal and illegal writes with sparse valid strobes. A behavioural model checks every clock.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int unsigned XW_DEFAULT = 16;
  localparam int unsigned YW_DEFAULT = 16;

  function automatic bit width_legal(input int unsigned code, input int unsigned xw);
    return (code >= 1) && (code <= xw);
  endfunction
endpackage

// File: rtl/dmap_width_reg.sv
module dmap_width_reg #(
  parameter int unsigned XW = dmap_pkg::XW_DEFAULT,
  localparam int unsigned CW = $clog2(XW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] width_q
);
  logic legal;

  always_comb legal = dmap_pkg::width_legal(int'(wdata), XW);

  always_ff @(posedge clk) begin
    if (rst)              width_q <= CW'(XW);
    else if (we && legal) width_q <= wdata;
  end

  // R3: an illegal code leaves the width untouched
  assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata == '0 || wdata > CW'(XW))) |=> $stable(width_q));

  // R2: the stored width always stays inside 1..XW
  assert_width_range_R2: assert property (@(posedge clk) disable iff (rst)
    (width_q != '0) && (width_q <= CW'(XW)));
endmodule

// File: rtl/dmap_xfield.sv
module dmap_xfield #(
  parameter int unsigned XW = dmap_pkg::XW_DEFAULT,
  localparam int unsigned CW = $clog2(XW) + 1
) (
  input  logic [CW-1:0] width,
  input  logic [XW-1:0] x,
  output logic [XW-1:0] x_kept,
  output logic          over
);
  logic [XW-1:0] keep_mask;

  always_comb begin
    keep_mask = {XW{1'b1}} >> (CW'(XW) - width);
    x_kept    = x & keep_mask;
    over      = |(x & ~keep_mask);
  end
endmodule

// File: rtl/dmap_yshift.sv
module dmap_yshift #(
  parameter int unsigned XW = dmap_pkg::XW_DEFAULT,
  parameter int unsigned YW = dmap_pkg::YW_DEFAULT,
  localparam int unsigned SW = $clog2(XW),
  localparam int unsigned PW = XW + YW
) (
  input  logic [YW-1:0] y,
  input  logic [SW-1:0] shamt,
  output logic [PW-1:0] placed
);
  logic [PW-1:0] stage [SW+1];

  assign stage[SW] = {y, {XW{1'b0}}};

  for (genvar k = SW - 1; k >= 0; k--) begin : g_stage
    assign stage[k] = shamt[k] ? (stage[k+1] >> (2 ** k)) : stage[k+1];
  end

  assign placed = stage[0];
endmodule

// File: rtl/dmap_packer.sv
module dmap_packer #(
  parameter int unsigned XW = dmap_pkg::XW_DEFAULT,
  parameter int unsigned YW = dmap_pkg::YW_DEFAULT,
  localparam int unsigned CW = $clog2(XW) + 1,
  localparam int unsigned SW = $clog2(XW),
  localparam int unsigned PW = XW + YW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_xbits,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  output logic          out_valid,
  output logic [PW-1:0] out_addr,
  output logic          out_range_err
);
  logic [CW-1:0] width_q;
  logic [SW-1:0] shamt;
  logic [XW-1:0] x_kept;
  logic          x_over;
  logic [PW-1:0] y_placed;

  dmap_width_reg #(.XW(XW)) u_width (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_xbits), .width_q(width_q)
  );

  assign shamt = SW'(CW'(XW) - width_q);

  dmap_xfield #(.XW(XW)) u_xfield (
    .width(width_q), .x(in_x), .x_kept(x_kept), .over(x_over)
  );

  dmap_yshift #(.XW(XW), .YW(YW)) u_yshift (
    .y(in_y), .shamt(shamt), .placed(y_placed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_addr      <= '0;
      out_range_err <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      out_range_err <= in_valid && x_over;
      if (in_valid) out_addr <= y_placed | PW'(x_kept);
    end
  end

  // R5: valid follows the input strobe with one cycle of latency
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: the range flag appears only together with a valid result
  assert_err_needs_valid_R6: assert property (@(posedge clk) disable iff (rst)
    out_range_err |-> out_valid);

  // R7: the address holds across idle cycles
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_addr));

  // R4: low x bits pass straight through when the width is full
  assert_full_width_low_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && width_q == CW'(XW)) |=> (out_addr[XW-1:0] == $past(in_x)));
endmodule

// File: tb/tb_dmap_packer.sv
module tb_dmap_packer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_xbits = '0;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_range_err;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  int          m_w = 16;
  logic        m_valid = 1'b0;
  logic [31:0] m_addr = '0;
  logic        m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmap_packer dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_xbits(cfg_xbits),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_addr(out_addr), .out_range_err(out_range_err)
  );

  function automatic logic [31:0] pack(input int w, input logic [15:0] x, input logic [15:0] y);
    longint unsigned r;
    r = (longint'(y) << w) | (longint'(x) & ((64'd1 << w) - 1));
    return r[31:0];
  endfunction

  function automatic logic over(input int w, input logic [15:0] x);
    return (w < 16) && ((int'(x) >> w) != 0);
  endfunction

  // model update: uses the width in force before any write this cycle (R9)
  always @(posedge clk) begin
    if (rst) begin
      m_w = 16; m_valid = 0; m_addr = '0; m_err = 0;
    end else begin
      m_valid = in_valid;
      m_err   = in_valid && over(m_w, in_x);
      if (in_valid) m_addr = pack(m_w, in_x, in_y);
      if (cfg_we && cfg_xbits >= 1 && cfg_xbits <= 16) m_w = int'(cfg_xbits);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(out_valid == m_valid, "R5", "out_valid", 32'(out_valid), 32'(m_valid));
      check(out_addr == m_addr, "R4", "out_addr", out_addr, m_addr);
      check(out_range_err == m_err, "R6", "out_range_err", 32'(out_range_err), 32'(m_err));
    end
  end

  task automatic access(input logic [15:0] x, input logic [15:0] y);
    in_valid = 1; in_x = x; in_y = y;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic write_w(input logic [4:0] w);
    cfg_we = 1; cfg_xbits = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && out_addr == 0 && out_range_err == 0, "R1", "reset outputs",
          {out_valid, out_range_err, out_addr[29:0]}, 32'd0);
    rst = 0;
    // R1/R8: default width is a plain join
    access(16'h1234, 16'hABCD);
    check(out_addr == 32'hABCD1234, "R8", "full width join", out_addr, 32'hABCD1234);
    check(out_range_err == 0, "R1", "no error at width 16", 32'(out_range_err), 0);
    // R7: idle cycle keeps the address
    @(negedge clk);
    check(out_addr == 32'hABCD1234 && !out_valid, "R7", "hold when idle", out_addr, 32'hABCD1234);
    // R2/R8: width 1
    write_w(5'd1);
    access(16'h0001, 16'hFFFF);
    check(out_addr == 32'h0001FFFF, "R8", "width 1", out_addr, 32'h0001FFFF);
    // R3: code 0 ignored, width stays 1, so x=3 is out of range
    write_w(5'd0);
    access(16'h0003, 16'h0002);
    check(out_range_err == 1, "R3", "code 0 ignored (err)", 32'(out_range_err), 1);
    check(out_addr == 32'h00000005, "R3", "code 0 ignored (addr)", out_addr, 32'h5);
    // R3: code 17 ignored
    write_w(5'd17);
    access(16'h0002, 16'h0000);
    check(out_range_err == 1, "R3", "code 17 ignored", 32'(out_range_err), 1);
    // R9: write width 8 in the same cycle as an access; access uses width 1
    cfg_we = 1; cfg_xbits = 5'd8;
    in_valid = 1; in_x = 16'h00F0; in_y = 16'h0003;
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    check(out_addr == 32'h00000006 && out_range_err, "R9", "old width used", out_addr, 32'h6);
    // R2: width 8 now in force
    access(16'h00F0, 16'h0003);
    check(out_addr == 32'h000003F0 && !out_range_err, "R2", "width 8", out_addr, 32'h3F0);
    // R6: bit 8 set is out of range at width 8
    access(16'h0100, 16'h0001);
    check(out_range_err == 1, "R6", "bit at W flagged", 32'(out_range_err), 1);
    @(negedge clk);
    check(out_range_err == 0, "R6", "flag low when idle", 32'(out_range_err), 0);

    // random stream, checked by the model every clock
    for (int i = 0; i < 2000; i++) begin
      cfg_we    = ($urandom_range(0, 7) == 0);
      cfg_xbits = 5'($urandom_range(0, 31));
      in_valid  = ($urandom_range(0, 2) != 0);
      in_x      = ($urandom_range(0, 1) != 0) ? 16'($urandom) : 16'($urandom_range(0, 255));
      in_y      = 16'($urandom);
      @(negedge clk);
    end
    cfg_we = 0; in_valid = 0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule